// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits between the byte stream coming out of an Ethernet receive MAC and the path that writes frame data to memory. It counts every byte of each frame, from the first destination-address byte through the last checksum byte, and compares the running count against a maximum length. That maximum comes from a programmable register that software reads and writes over a simple 32-bit register port. Bytes beyond the maximum are dropped. The four checksum bytes at the tail of a frame count toward the limit, but they are never passed on.

A four-entry hold-back line delays the forwarded bytes. When a frame ends, the line still holds the four checksum bytes, and they can be thrown away. If a frame runs past the maximum, the held bytes are released instead, so the forwarded part always ends exactly at the limit. When each frame ends, a one-cycle status pulse reports the counted length and whether the frame was cut. The counted length saturates at its all-ones value and does not wrap.

The maximum length is decoded from the register code and latched at start of frame. Each frame is therefore judged against one value, even if the register is rewritten while the frame is arriving. While the receive-enable input is high, register writes are refused.

Top module: `rx_len_limiter`

## Requirements
- R1: The register reads as 32 bits. Bits 17:0 hold the written value. Bits 31:18 always read 0, whatever was written. After reset the register reads 0.
- R2: A register write made while `rx_en` is 1 leaves the register unchanged.
- R3: Any code from 0 to 0x5EE gives a maximum length of 1518 bytes.
- R4: Any code from 0x5EF to 0x1FFFF gives a maximum length equal to the code, in bytes.
- R5: Any code from 0x20000 to 0x3FFFF gives a maximum length of 131072 bytes.
- R6: The counted length covers every byte from the start-of-frame byte through the end-of-frame byte. One cycle after the end-of-frame byte is taken, `st_valid` pulses for one cycle. In that cycle `st_len` carries the count and `st_trunc` is 1 exactly when the count exceeds the maximum.
- R7: A frame of n bytes with n no greater than the maximum forwards its first n-4 bytes, in order, with `out_last` set on byte n-4. Its last four bytes are never forwarded. A frame of 4 bytes or fewer forwards nothing.
- R8: A frame longer than the maximum forwards exactly the first maximum-length bytes, in order, with `out_last` set on the final one. All later bytes are discarded.
- R9: The maximum length is taken from the register at the start-of-frame byte. A register change during the frame affects only later frames.
- R10: An input byte with `in_valid` high, arriving outside a frame and without `in_sof`, produces no output byte and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; blocks register writes while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the last kept byte of its frame |
| st_valid | output | 1 | One-cycle frame status pulse |
| st_len | output | 18 | Counted frame length, checksum bytes included |
| st_trunc | output | 1 | Frame exceeded the maximum length |

## Verification
The hardest case to reach from the ports is the top end of the limit range, a frame just one byte over the 131072-byte ceiling. The only way to get there is to program a code in the saturated band and stream more than 131 thousand bytes without a gap. The bench does exactly that, and a running monitor checks every forwarded byte against its position, so a slip anywhere in that long frame is caught. The mid-frame register change is reached by issuing a write from inside the frame-sending loop. The write lands partway through the frame, and the frame that follows shows the new limit.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int LEN_W  = 18;
  localparam int BUS_W  = 32;
  localparam int DATA_W = 8;
  localparam int HOLD_N = 4;

  localparam logic [LEN_W-1:0] FLOOR_CODE = LEN_W'(18'h005EE);
  localparam logic [LEN_W-1:0] FLOOR_LEN  = LEN_W'(1518);
  localparam logic [LEN_W-1:0] CEIL_LEN   = LEN_W'(18'h20000);

  // Decode a register code into the effective byte limit.
  function automatic logic [LEN_W-1:0] rxl_eff_limit(input logic [LEN_W-1:0] code);
    if (code <= FLOOR_CODE)     return FLOOR_LEN;
    else if (code >= CEIL_LEN)  return CEIL_LEN;
    else                        return code;
  endfunction

  // Increment that sticks at all-ones.
  function automatic logic [LEN_W-1:0] rxl_sat_inc(input logic [LEN_W-1:0] v);
    if (&v) return v;
    else    return v + LEN_W'(1);
  endfunction
endpackage

// File: rtl/rxl_cfg_reg.sv
module rxl_cfg_reg #(
  parameter int BUS_W = rxl_pkg::BUS_W,
  parameter int LEN_W = rxl_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [LEN_W-1:0] code,
  output logic             wr_refused
);
  logic [LEN_W-1:0] code_q;

  assign wr_refused = we && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                code_q <= '0;
    else if (we && !rx_en)     code_q <= wdata[LEN_W-1:0];
  end

  assign code  = code_q;
  assign rdata = {{(BUS_W-LEN_W){1'b0}}, code_q};
endmodule

// File: rtl/rxl_frame_ctl.sv
module rxl_frame_ctl #(
  parameter int LEN_W = rxl_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LEN_W-1:0] code,
  output logic             beat_sof,
  output logic             keep,
  output logic             trig,
  output logic             good_end,
  output logic             st_valid,
  output logic [LEN_W-1:0] st_len,
  output logic             st_trunc
);
  import rxl_pkg::*;

  logic             active_q;
  logic [LEN_W-1:0] cnt_q, lim_q;
  logic             beat, fin;
  logic [LEN_W-1:0] idx, lim_now;

  assign beat     = in_valid && (in_sof || active_q);
  assign beat_sof = beat && in_sof;
  assign idx      = in_sof ? LEN_W'(1) : rxl_sat_inc(cnt_q);
  assign lim_now  = in_sof ? rxl_eff_limit(code) : lim_q;
  assign keep     = beat && (idx <= lim_now);
  assign trig     = beat && (idx == lim_now + LEN_W'(1));
  assign fin      = beat && in_eof;
  assign good_end = fin && (idx <= lim_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= FLOOR_LEN;
      st_valid <= 1'b0;
      st_len   <= '0;
      st_trunc <= 1'b0;
    end else begin
      st_valid <= fin;
      st_len   <= fin ? idx : '0;
      st_trunc <= fin && (idx > lim_now);
      if (beat) begin
        active_q <= !in_eof;
        cnt_q    <= idx;
        lim_q    <= lim_now;
      end
    end
  end
endmodule

// File: rtl/rxl_holdback.sv
module rxl_holdback #(
  parameter int DATA_W = rxl_pkg::DATA_W,
  parameter int HOLD_N = rxl_pkg::HOLD_N,
  localparam int CW    = $clog2(HOLD_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              end_ok,
  input  logic              trig,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CW-1:0]     fill,
  output logic              drain
);
  logic [DATA_W-1:0] hold_q [HOLD_N];
  logic [CW-1:0]     fill_q, flush_q;
  logic              full, pass, shift;

  assign full  = (fill_q == CW'(HOLD_N));
  assign drain = (flush_q != '0);
  assign pass  = push && full && !drain;
  assign shift = drain || pass;
  assign fill  = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      flush_q   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (clr) begin
        flush_q <= '0;
        fill_q  <= push ? CW'(1) : '0;
      end else if (drain) begin
        out_valid <= 1'b1;
        out_data  <= hold_q[0];
        out_last  <= (flush_q == CW'(1));
        flush_q   <= flush_q - CW'(1);
        fill_q    <= fill_q - CW'(1);
      end else if (trig) begin
        flush_q <= fill_q;
      end else if (push) begin
        if (full) begin
          out_valid <= 1'b1;
          out_data  <= hold_q[0];
          out_last  <= end_ok;
        end else begin
          fill_q <= fill_q + CW'(1);
        end
        if (end_ok) fill_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < HOLD_N; g++) begin : g_slot
    if (g == HOLD_N - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (clr && push)                            hold_q[g] <= (g == 0) ? din : hold_q[g];
        else if (shift)                             hold_q[g] <= din;
        else if (push && fill_q == CW'(g))          hold_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (clr && push)                            hold_q[g] <= (g == 0) ? din : hold_q[g];
        else if (shift)                             hold_q[g] <= hold_q[g+1];
        else if (push && fill_q == CW'(g))          hold_q[g] <= din;
      end
    end
  end
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter #(
  parameter int BUS_W  = rxl_pkg::BUS_W,
  parameter int LEN_W  = rxl_pkg::LEN_W,
  parameter int DATA_W = rxl_pkg::DATA_W,
  parameter int HOLD_N = rxl_pkg::HOLD_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              cfg_we,
  input  logic [BUS_W-1:0]  cfg_wdata,
  output logic [BUS_W-1:0]  cfg_rdata,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              st_valid,
  output logic [LEN_W-1:0]  st_len,
  output logic              st_trunc
);
  localparam int CW = $clog2(HOLD_N + 1);

  logic [LEN_W-1:0] cfg_code;
  logic             cfg_refused;
  logic             ev_sof, ev_keep, ev_trig, ev_good_end;
  logic [CW-1:0]    hb_fill;
  logic             hb_drain;

  rxl_cfg_reg #(.BUS_W(BUS_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .code(cfg_code), .wr_refused(cfg_refused)
  );

  rxl_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .code(cfg_code), .beat_sof(ev_sof), .keep(ev_keep), .trig(ev_trig),
    .good_end(ev_good_end), .st_valid(st_valid), .st_len(st_len), .st_trunc(st_trunc)
  );

  rxl_holdback #(.DATA_W(DATA_W), .HOLD_N(HOLD_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(ev_sof), .push(ev_keep), .din(in_data),
    .end_ok(ev_good_end), .trig(ev_trig), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .fill(hb_fill), .drain(hb_drain)
  );
endmodule

// File: rtl/rxl_chk.sv
module rxl_chk #(
  parameter int BUS_W  = 32,
  parameter int LEN_W  = 18,
  parameter int HOLD_N = 4,
  localparam int CW    = $clog2(HOLD_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_refused,
  input logic [BUS_W-1:0] cfg_rdata,
  input logic             out_valid,
  input logic             out_last,
  input logic             st_valid,
  input logic             st_trunc,
  input logic [LEN_W-1:0] st_len,
  input logic [CW-1:0]    hb_fill,
  input logic             hb_drain,
  input logic             ev_trig,
  input logic             ev_keep
);
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[BUS_W-1:LEN_W] == '0);

  a_r2_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_refused |=> $stable(cfg_rdata));

  a_r7_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hb_fill <= CW'(HOLD_N));

  a_r8_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r8_drain_emits: assert property (@(posedge clk) disable iff (!rst_n)
    hb_drain |=> out_valid);

  a_r8_no_keep_after_cut: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trig |-> !ev_keep);

  a_r6_trunc_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_trunc) |-> (st_len > LEN_W'(1518)));

  a_r6_trunc_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_trunc |-> st_valid);
endmodule

bind rx_len_limiter rxl_chk #(.BUS_W(BUS_W), .LEN_W(LEN_W), .HOLD_N(HOLD_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_refused(cfg_refused), .cfg_rdata(cfg_rdata),
  .out_valid(out_valid), .out_last(out_last), .st_valid(st_valid), .st_trunc(st_trunc),
  .st_len(st_len), .hb_fill(hb_fill), .hb_drain(hb_drain), .ev_trig(ev_trig),
  .ev_keep(ev_keep)
);

// File: tb/tb_rx_len_limiter.sv
module tb_rx_len_limiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0, out_data;
  logic        out_valid, out_last, st_valid, st_trunc;
  logic [17:0] st_len;

  int vecs = 0, fails = 0;
  bit done = 1'b0;

  int mon_seed = 0, o_cnt = 0, o_bad = 0, l_cnt = 0, l_pos = -1, s_cnt = 0;
  int s_len = 0;
  bit s_tr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_len_limiter dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .st_valid(st_valid), .st_len(st_len), .st_trunc(st_trunc)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 13) + (seed * 7) + (i >>> 8));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (out_data !== pat(mon_seed, o_cnt)) o_bad++;
        if (out_last) begin l_cnt++; l_pos = o_cnt; end
        o_cnt++;
      end
      if (st_valid) begin s_cnt++; s_len = int'(st_len); s_tr = st_trunc; end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear(input int seed);
    @(posedge clk); #1;
    mon_seed = seed; o_cnt = 0; o_bad = 0; l_cnt = 0; l_pos = -1; s_cnt = 0;
    s_len = 0; s_tr = 1'b0;
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed, input int wr_at, input logic [31:0] wr_v);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data  = pat(seed, i);
      cfg_we   = (i == wr_at); cfg_wdata = wr_v;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
    repeat (12) @(posedge clk);
  endtask

  task automatic frame_case(input string req, input int len, input int lim, input int seed,
                            input int wr_at, input logic [31:0] wr_v);
    int exp_o, exp_l;
    mon_clear(seed);
    send_frame(len, seed, wr_at, wr_v);
    @(negedge clk);
    exp_o = (len <= lim) ? ((len > 4) ? len - 4 : 0) : lim;
    exp_l = (exp_o > 0) ? 1 : 0;
    chk(o_cnt == exp_o, {req, " forwarded count"}, o_cnt, exp_o);
    chk(o_bad == 0, {req, " forwarded data order"}, o_bad, 0);
    chk(l_cnt == exp_l, {req, " last count"}, l_cnt, exp_l);
    if (exp_l == 1) chk(l_pos == exp_o - 1, {req, " last position"}, l_pos, exp_o - 1);
    chk(s_cnt == 1, {req, " R6 status pulses"}, s_cnt, 1);
    chk(s_len == len, {req, " R6 status length"}, s_len, len);
    chk(s_tr == (len > lim), {req, " R6 truncated flag"}, s_tr, (len > lim));
  endtask

  // R1, R2: register access
  task automatic t_register();
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1 reset value", cfg_rdata, 0);
    chk(!out_valid && !st_valid, "R1 reset outputs idle", {out_valid, st_valid}, 0);
    cfg_write(32'hFFFF_FFFF);
    @(negedge clk);
    chk(cfg_rdata == 32'h0003_FFFF, "R1 writable field only", cfg_rdata, 32'h3FFFF);
    cfg_write(32'h0000_0800);
    @(posedge clk); #1; rx_en = 1'b1;
    cfg_write(32'h0000_0123);
    @(negedge clk);
    chk(cfg_rdata == 32'h0000_0800, "R2 write while enabled", cfg_rdata, 32'h800);
    @(posedge clk); #1; rx_en = 1'b0;
  endtask

  // R10: stray bytes outside a frame
  task automatic t_stray();
    mon_clear(0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = 8'(i); in_eof = (i == 9);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(o_cnt == 0, "R10 stray bytes forwarded", o_cnt, 0);
    chk(s_cnt == 0, "R10 stray status", s_cnt, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_register();
    t_stray();
    cfg_write(32'h0);
    frame_case("R7 short frame", 3, 1518, 1, -1, 0);
    frame_case("R7 single byte", 1, 1518, 2, -1, 0);
    frame_case("R7 min frame", 64, 1518, 3, -1, 0);
    frame_case("R3 at limit", 1518, 1518, 4, -1, 0);
    frame_case("R8 R3 one over", 1519, 1518, 5, -1, 0);
    cfg_write(32'h5EE);
    frame_case("R3 floor code", 1519, 1518, 6, -1, 0);
    cfg_write(32'h5EF);
    frame_case("R4 code 0x5EF fits", 1519, 1519, 7, -1, 0);
    frame_case("R4 R8 code 0x5EF over", 1520, 1519, 8, -1, 0);
    cfg_write(32'h0);
    frame_case("R9 latched limit", 1600, 1518, 9, 100, 32'h800);
    frame_case("R4 R9 new limit", 1600, 2048, 10, -1, 0);
    cfg_write(32'h3FFFF);
    frame_case("R5 R8 ceiling over", 131073, 131072, 11, -1, 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule